// File: doc/BRIEF.md
# Eight-bit increment/decrement execution unit

This unit carries out the single-operand add-one and subtract-one instructions of a small 8-bit accumulator CPU. The caller presents a one-byte opcode together with a one-cycle start strobe. The unit decodes the opcode into an operation and a target. It updates its own seven-register file (A, B, C, D, E, H, L) or, for the memory-indirect slot, runs a read-modify-write on the byte addressed by the H:L pair. It then writes the zero, subtract and half-carry flags and signals completion with a one-cycle done pulse.

A register target takes four clocks and the memory target takes twelve. Opcodes outside the sixteen supported encodings are refused with a one-cycle illegal pulse, and no state changes. The register contents and the flags are brought out as read-only views so that the surrounding datapath can use them.

Top module: `incdec_unit`

## Requirements
- R1: An opcode is legal when bits 7:6 are 00 and bits 2:1 are 10. Bit 0 selects the operation (0 = add one, 1 = subtract one). Bits 5:3 select the target with codes 0..7 = B, C, D, E, H, L, memory at H:L, A. `reg_view` byte k holds the register with target code k, and byte 6 reads zero.
- R2: The result is the operand plus or minus one, modulo 256: 0xFF plus one gives 0x00, and 0x00 minus one gives 0xFF.
- R3: The Z flag (`flags` bit 3) is 1 exactly when the 8-bit result is zero.
- R4: The N flag (`flags` bit 2) is 1 after a subtract and 0 after an add.
- R5: The H flag (`flags` bit 1) is 1 when an add carries out of bit 3 (the operand's low nibble is 0xF), or when a subtract borrows into bit 3 (the operand's low nibble is 0x0).
- R6: The carry flag (`flags` bit 0) is never changed by any instruction.
- R7: For a register target, `done` is high for exactly one cycle, in the 4th cycle after the edge that accepts `start`. The new register value and flags are visible in that cycle.
- R8: For the memory target, `done` comes in the 12th cycle. The unit reads the byte at address {H,L}, where read data is valid one cycle after the address. It writes the result back to {H,L} with exactly one write-enable cycle, issued after the flags are updated.
- R9: A start with an illegal opcode gives a one-cycle `illegal` pulse in the next cycle. It gives no done and changes no register, flag or memory.
- R10: A start that arrives while an instruction is in progress, including the done cycle, is ignored.
- R11: A synchronous active-low reset clears all registers and flags to zero and returns the unit to idle with `done` and `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to execute `opcode` |
| opcode | input | 8 | Instruction byte |
| mem_addr | output | 16 | Memory address, {H,L} |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable, one cycle per memory instruction |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a refused opcode |
| reg_view | output | 64 | Register contents, byte k = target code k |
| flags | output | 4 | {Z, N, H, C} |

## Verification
A corrupted step counter or a wrongly latched target shows first on `done`. The pulse comes early, late, twice, or not at all, and a deviation of even one cycle is caught in the same instruction. A bad operand path or flag rule is visible on `reg_view` and `flags` in the done cycle itself. A memory sequencing fault shows in the bench memory as a missing write, a double write or a wrong address before the next instruction starts. Illegal and overlapping starts are checked by confirming that every view byte, the flags and the memory stay unchanged.

// File: rtl/incdec_pkg.sv
// Shared types for the increment/decrement unit.
// Assumes the target code is taken straight from opcode bits 5:3.
package incdec_pkg;
    typedef enum logic [2:0] {
        TGT_B   = 3'd0,
        TGT_C   = 3'd1,
        TGT_D   = 3'd2,
        TGT_E   = 3'd3,
        TGT_H   = 3'd4,
        TGT_L   = 3'd5,
        TGT_MEM = 3'd6,
        TGT_A   = 3'd7
    } target_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;
endpackage

// File: rtl/incdec_decode.sv
// Opcode decoder: tells whether a byte is one of the sixteen supported
// encodings, which way it counts and which slot it targets.
// Purely combinational; assumes an 8-bit opcode.
module incdec_decode
    import incdec_pkg::*;
(
    input  logic [7:0] op,
    output logic       legal,
    output logic       is_dec,
    output target_e    target
);
    // Field extraction and legality test
    always_comb begin
        legal  = (op[7:6] == 2'b00) && (op[2:1] == 2'b10);
        is_dec = op[0];
        target = target_e'(op[5:3]);
    end
endmodule

// File: rtl/incdec_alu.sv
// Add-one / subtract-one datapath with zero and nibble-carry detection.
// Combinational; assumes WIDTH is at least NIB + 1.
module incdec_alu #(
    parameter int WIDTH = 8,
    parameter int NIB   = 4
) (
    input  logic [WIDTH-1:0] operand,
    input  logic             is_dec,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             half
);
    localparam logic [NIB-1:0] NIB_ONES = '1;

    // Result and flag derivation
    always_comb begin
        if (is_dec) begin
            result = operand - WIDTH'(1);
            half   = (operand[NIB-1:0] == '0);
        end else begin
            result = operand + WIDTH'(1);
            half   = (operand[NIB-1:0] == NIB_ONES);
        end
        zero = (result == '0);
    end
endmodule

// File: rtl/incdec_regfile.sv
// Register file indexed by target code, one write port and one read port.
// Slot HOLE is the memory-indirect slot and holds no storage; it reads zero.
module incdec_regfile #(
    parameter int WIDTH = 8,
    parameter int SLOTS = 8,
    parameter int HOLE  = 6,
    localparam int AW   = $clog2(SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [WIDTH-1:0]       wdata,
    input  logic [AW-1:0]          raddr,
    output logic [WIDTH-1:0]       rdata,
    output logic [SLOTS*WIDTH-1:0] view
);
    logic [WIDTH-1:0] slot_q [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k == HOLE) begin : g_hole
            assign slot_q[k] = '0;
        end else begin : g_reg
            logic [WIDTH-1:0] val_q;
            // Holds one register; cleared by reset, loaded on a matching write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    val_q <= '0;
                else if (we && (waddr == AW'(k)))
                    val_q <= wdata;
            end
            assign slot_q[k] = val_q;
        end
        assign view[k*WIDTH +: WIDTH] = slot_q[k];
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/incdec_unit.sv
// Top of the increment/decrement execution unit. Accepts one instruction
// when idle, steps a cycle counter through either the short register
// sequence or the longer read-modify-write sequence, and pulses done at
// the end. Assumes a synchronous memory whose read data follows the
// address by one cycle; mem_addr is driven from H:L at all times.
module incdec_unit
    import incdec_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int REG_CYCLES = 4,
    parameter int MEM_CYCLES = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         opcode,
    output logic [2*WIDTH-1:0] mem_addr,
    input  logic [WIDTH-1:0]   mem_rdata,
    output logic [WIDTH-1:0]   mem_wdata,
    output logic               mem_we,
    output logic               done,
    output logic               illegal,
    output logic [8*WIDTH-1:0] reg_view,
    output logic [3:0]         flags
);
    localparam int CNT_W = $clog2(MEM_CYCLES + 1);
    localparam logic [CNT_W-1:0] REG_LAST = CNT_W'(REG_CYCLES);
    localparam logic [CNT_W-1:0] MEM_LAST = CNT_W'(MEM_CYCLES);
    localparam logic [CNT_W-1:0] REG_STEP = CNT_W'(REG_CYCLES - 1);
    localparam logic [CNT_W-1:0] RD_STEP  = CNT_W'(MEM_CYCLES / 3);
    localparam logic [CNT_W-1:0] MOD_STEP = CNT_W'((2 * MEM_CYCLES) / 3);
    localparam logic [CNT_W-1:0] WR_STEP  = CNT_W'(MEM_CYCLES - 2);

    logic             dec_legal, dec_is_dec;
    target_e          dec_tgt;
    logic             busy_q, dec_q, ill_q;
    logic [CNT_W-1:0] cnt_q;
    target_e          tgt_q;
    logic [WIDTH-1:0] mdata_q, operand, alu_res, rf_rdata;
    logic             alu_z, alu_h, is_mem, rf_we, upd_flags;
    flags_t           flags_q;

    incdec_decode u_decode (
        .op     (opcode),
        .legal  (dec_legal),
        .is_dec (dec_is_dec),
        .target (dec_tgt)
    );

    incdec_regfile #(.WIDTH(WIDTH), .SLOTS(8), .HOLE(int'(TGT_MEM))) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (tgt_q),
        .wdata (alu_res),
        .raddr (tgt_q),
        .rdata (rf_rdata),
        .view  (reg_view)
    );

    incdec_alu #(.WIDTH(WIDTH), .NIB(WIDTH / 2)) u_alu (
        .operand (operand),
        .is_dec  (dec_q),
        .result  (alu_res),
        .zero    (alu_z),
        .half    (alu_h)
    );

    // Step decode: which cycle writes the register, the flags, the memory
    always_comb begin
        is_mem    = (tgt_q == TGT_MEM);
        operand   = is_mem ? mdata_q : rf_rdata;
        done      = busy_q && (cnt_q == (is_mem ? MEM_LAST : REG_LAST));
        rf_we     = busy_q && !is_mem && (cnt_q == REG_STEP);
        upd_flags = busy_q && (is_mem ? (cnt_q == MOD_STEP) : (cnt_q == REG_STEP));
        mem_we    = busy_q && is_mem && (cnt_q == WR_STEP);
        mem_wdata = mdata_q;
        mem_addr  = {reg_view[int'(TGT_H)*WIDTH +: WIDTH],
                     reg_view[int'(TGT_L)*WIDTH +: WIDTH]};
        illegal   = ill_q;
        flags     = flags_q;
    end

    // Sequencer: accept, count, capture memory data, update flags, retire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            tgt_q   <= TGT_B;
            dec_q   <= 1'b0;
            ill_q   <= 1'b0;
            mdata_q <= '0;
            flags_q <= '0;
        end else begin
            ill_q <= start && !busy_q && !dec_legal;
            if (!busy_q) begin
                if (start && dec_legal) begin
                    busy_q <= 1'b1;
                    cnt_q  <= CNT_W'(1);
                    tgt_q  <= dec_tgt;
                    dec_q  <= dec_is_dec;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (is_mem && cnt_q == RD_STEP)
                    mdata_q <= mem_rdata;
                if (is_mem && cnt_q == MOD_STEP)
                    mdata_q <= alu_res;
                if (upd_flags) begin
                    flags_q.z <= alu_z;
                    flags_q.n <= dec_q;
                    flags_q.h <= alu_h;
                end
                if (done) begin
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                end
            end
        end
    end

    // R7: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: memory writes only for the memory target and only one cycle long
    a_r8_we_mem_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy_q && is_mem && !done));
    a_r8_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R9: a refused opcode never starts an instruction
    a_r9_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy_q && !done));

    // R4: subtract flag matches the operation at retirement
    a_r4_n_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_q.n == dec_q));

    // R3: zero flag agrees with the register that was written
    a_r3_z_matches_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_mem) |-> (flags_q.z == (rf_rdata == '0)));

    // R10: an instruction in flight runs on without restart
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !done) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: tb/incdec_unit_bench.sv
`timescale 1ns/1ps
module incdec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        done;
    logic        illegal;
    logic [63:0] reg_view;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  mem [256];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_addr = 8'h00;
    logic [7:0]  poke_data = 8'h00;
    int          wr_count = 0;
    logic [15:0] last_waddr = 16'h0;

    logic [7:0]  exp_reg [8];
    logic        ez = 1'b0, en = 1'b0, eh = 1'b0;

    always #4 clk = ~clk;

    incdec_unit u_incdec_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .done      (done),
        .illegal   (illegal),
        .reg_view  (reg_view),
        .flags     (flags)
    );

    // Synchronous memory model with a bench-side preload port
    always @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_data;
        else if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_count           <= wr_count + 1;
            last_waddr         <= mem_addr;
        end
        mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] exp_view();
        logic [63:0] v = '0;
        for (int k = 0; k < 8; k++)
            if (k != 6) v[k*8 +: 8] = exp_reg[k];
        return v;
    endfunction

    task automatic check_state(input string req);
        check(req, "reg_view", reg_view, exp_view());
        check(req, "flags", {60'h0, flags}, {60'h0, ez, en, eh, 1'b0});
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // Issue one legal opcode, compute the expected outcome, check timing and state
    task automatic run_op(input logic [7:0] op, input string req);
        int          tgt  = int'(op[5:3]);
        bit          dec  = op[0];
        int          len  = (tgt == 6) ? 12 : 4;
        logic [7:0]  maddr = exp_reg[5];
        logic [15:0] full_addr = {exp_reg[4], exp_reg[5]};
        logic [7:0]  opnd = (tgt == 6) ? mem[maddr] : exp_reg[tgt];
        logic [7:0]  res  = dec ? opnd - 8'd1 : opnd + 8'd1;
        int          wr0  = wr_count;
        int          n    = 0;
        ez = (res == 8'h00);
        en = dec;
        eh = dec ? (opnd[3:0] == 4'h0) : (opnd[3:0] == 4'hF);
        if (tgt != 6) exp_reg[tgt] = res;
        @(negedge clk);
        opcode = op; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(req, "done cycle", 64'(n), 64'(len));
        check_state(req);
        @(negedge clk);
        check("R7", "done width", {63'h0, done}, 64'h0);
        if (tgt == 6) begin
            check("R8", "write count", 64'(wr_count - wr0), 64'h1);
            check("R8", "write addr", {48'h0, last_waddr}, {48'h0, full_addr});
            check("R2", "memory byte", {56'h0, mem[maddr]}, {56'h0, res});
        end else begin
            check(req, "no memory write", 64'(wr_count - wr0), 64'h0);
        end
    endtask

    task automatic t_reset();
        check("R11", "reg_view", reg_view, 64'h0);
        check("R11", "flags", {60'h0, flags}, 64'h0);
        check("R11", "done/illegal", {62'h0, done, illegal}, 64'h0);
    endtask

    // R1: one add per register slot, checks decode order of bits 5:3
    task automatic t_each_register();
        for (int k = 0; k < 8; k++)
            if (k != 6) run_op(8'h04 | 8'(k << 3), "R1");
    endtask

    // R2/R3/R5: wrap around and borrows on register B
    task automatic t_wrap();
        run_op(8'h05, "R3");   // B 1 -> 0, zero set, no borrow
        run_op(8'h05, "R2");   // B 0 -> FF, borrow into bit 3
        run_op(8'h04, "R3");   // B FF -> 00, carry out of bit 3, zero
    endtask

    // R5: add carry out of bit 3 on D at 0x0F
    task automatic t_half_add();
        for (int i = 0; i < 14; i++) run_op(8'h14, "R5");
        run_op(8'h14, "R5");   // D 0F -> 10
        run_op(8'h15, "R5");   // D 10 -> 0F, borrow
        run_op(8'h3D, "R4");   // A 1 -> 0 subtract
    endtask

    // R8: memory read-modify-write at {H,L}
    task automatic t_memory();
        poke(exp_reg[5], 8'h7F);
        run_op(8'h34, "R8");   // 7F -> 80, H set
        run_op(8'h35, "R8");   // 80 -> 7F, borrow
        poke(exp_reg[5], 8'h00);
        run_op(8'h35, "R8");   // 00 -> FF
    endtask

    // R9: refused opcodes leave everything alone
    task automatic t_illegal();
        logic [7:0] bad [4] = '{8'h00, 8'h07, 8'h44, 8'hC4};
        for (int i = 0; i < 4; i++) begin
            int wr0 = wr_count;
            @(negedge clk);
            opcode = bad[i]; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R9", "illegal pulse", {63'h0, illegal}, 64'h1);
            check("R9", "no done", {63'h0, done}, 64'h0);
            @(negedge clk);
            check("R9", "pulse width", {62'h0, illegal, done}, 64'h0);
            repeat (12) @(negedge clk);
            check("R9", "no done later", {63'h0, done}, 64'h0);
            check_state("R9");
            check("R9", "no write", 64'(wr_count - wr0), 64'h0);
        end
    endtask

    // R10: a second start mid-flight and in the done cycle is dropped
    task automatic t_busy();
        int n = 0;
        logic [7:0] maddr = exp_reg[5];
        logic [7:0] opnd  = mem[maddr];
        logic [7:0] res   = opnd + 8'd1;
        ez = (res == 8'h00); en = 1'b0; eh = (opnd[3:0] == 4'hF);
        @(negedge clk);
        opcode = 8'h34; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 20) begin
            if (n == 3) begin opcode = 8'h04; start = 1'b1; end
            else start = 1'b0;
            @(negedge clk);
            n++;
        end
        opcode = 8'h0C; start = 1'b1;       // start during the done cycle
        check("R10", "done cycle", 64'(n), 64'd12);
        @(negedge clk);
        start = 1'b0;
        repeat (8) begin
            check("R10", "no extra done", {63'h0, done}, 64'h0);
            @(negedge clk);
        end
        check_state("R10");
        check("R10", "memory byte", {56'h0, mem[maddr]}, {56'h0, res});
    endtask

    // R6: carry flag after all activity
    task automatic t_carry();
        check("R6", "carry bit", {63'h0, flags[0]}, 64'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int k = 0; k < 8; k++) exp_reg[k] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_each_register();
        t_wrap();
        t_half_add();
        t_memory();
        t_illegal();
        t_busy();
        t_carry();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule